// File: doc/BRIEF.md
# Chip-Select Access Sequencer

This block produces the strobe timing for a single access to a slow asynchronous memory or peripheral sitting behind one chip-select bank. A request is accepted with its direction, its address and a set of bank options. The block then runs the access through fixed phases: address latch, address-to-select setup, the active strobe window, a closing cycle, and an optional idle gap after reads. It drives an address-latch enable, a chip select, a write enable and an output enable. All strobes are active high at the block's ports; any pad inversion sits outside the block.

The active window ends in one of two ways. In internal mode, a wait-state counter ends it, and an acknowledge input can end it earlier. In external mode, only the acknowledge input ends it. A relaxed-timing option changes several phases at once: it lengthens the setup, doubles the wait count, drops the write strobes early, and takes part in selecting the idle gap after a read. Every option is sampled when the request is accepted and held for the whole access.

Top module: `csbus_timer`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle, including the whole reset state. A request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the following cycle until the access and any idle gap are over, even when `req_valid` stays high.
- R2: `bus_ale` is high in the cycles that directly follow acceptance. It lasts 1 cycle when `cfg_latch_delay` is 0. When `cfg_latch_delay` is 1 it lasts `cfg_latch_cycles` cycles, and a value of 0 counts as 1. `bus_addr` carries the captured address from the first latch cycle through the done cycle and is zero at all other times.
- R3: When `cfg_cs_delay` is 0, the active window starts directly after the latch phase. For any nonzero value there is 1 setup cycle with all strobes low, or 2 setup cycles when `cfg_relax` is 1.
- R4: In internal mode (`cfg_ext_term`=0), with no early acknowledge, the active window lasts W+1 cycles. W is `cfg_wait` (4 bits) or twice that value when `cfg_relax` is 1, so W is at most 30.
- R5: In internal mode, `ext_ack` high in active cycle j (counting from 0) with j<W ends the window after j+1 cycles. An acknowledge in the same cycle as counter expiry ends the access exactly once.
- R6: In external mode (`cfg_ext_term`=1), the counter has no effect. `ext_ack` high in active cycle j ends the window after j+1 cycles, including when j is larger than W.
- R7: `acc_done` is a one-cycle pulse in the cycle after the last active cycle. Under normal timing, `bus_cs` and the direction strobe stay high in that cycle.
- R8: In a write with `cfg_relax`=1, `bus_we` is low in the done cycle. `bus_cs` is also low in that cycle if `cfg_cs_delay` is nonzero.
- R9: `bus_oe` is driven only for reads and `bus_we` only for writes. Both are high in every active cycle of their own direction. Neither is high during latch, setup, gap or idle cycles.
- R10: After the done cycle of a read, the sequencer stays busy for 0, 1, 4 or 8 cycles, selected by {`cfg_relax`,`cfg_hold_ext`} = 00, 01, 10, 11. Writes add no gap.
- R11: `ext_ack` outside the active window (during the latch, done or idle cycles) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | AW | Access address |
| cfg_ext_term | input | 1 | 1 = only the acknowledge ends the access |
| cfg_relax | input | 1 | Relaxed timing for slow devices |
| cfg_hold_ext | input | 1 | Extended post-read hold, works with cfg_relax |
| cfg_latch_delay | input | 1 | Use programmed latch-enable length |
| cfg_latch_cycles | input | LCW | Latch-enable length when cfg_latch_delay is 1 |
| cfg_cs_delay | input | 2 | Address-to-chip-select setting, zero or nonzero |
| cfg_wait | input | WSW | Programmed wait-state count |
| ext_ack | input | 1 | External transfer acknowledge |
| bus_addr | output | AW | Address driven to the device |
| bus_ale | output | 1 | Address latch enable |
| bus_cs | output | 1 | Chip select |
| bus_we | output | 1 | Write enable |
| bus_oe | output | 1 | Output enable |
| acc_done | output | 1 | One-cycle end-of-access pulse |

## Verification
Two functions can fall in the same cycle: counter expiry of the internal wait count, and the external acknowledge. The bench raises `ext_ack` in the exact active cycle where the counter reaches zero, in both termination modes and across relaxed and normal wait counts. In internal mode the access must end once, with a window of W+1 cycles. In external mode the same coincidence must leave the counter inert, and a later acknowledge must still set the window length. The bench judges each case by the cycle in which `acc_done` appears and by the `bus_cs` span that comes before it.

// File: rtl/csbus_pkg.sv
// Package: shared types and helpers of the chip-select access sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package csbus_pkg;

    // Access phases, in the order the sequencer walks them.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LATCH  = 3'd1,
        PH_SETUP  = 3'd2,
        PH_ACTIVE = 3'd3,
        PH_END    = 3'd4,
        PH_GAP    = 3'd5
    } phase_t;

    // Idle cycles after a read, selected by {relax, hold_ext}.
    function automatic logic [3:0] read_gap_cycles(input logic relax, input logic hold_ext);
        logic [3:0] n;
        unique case ({relax, hold_ext})
            2'b00:   n = 4'd0;
            2'b01:   n = 4'd1;
            2'b10:   n = 4'd4;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

    // Larger of two widths, used to size shared counters.
    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/csbus_req_capture.sv
// Module: csbus_req_capture
// Captures direction, address and bank options when a request is taken and
// turns them into phase lengths for the sequencer. The latch length is also
// given combinationally from the raw inputs, because the sequencer loads it
// at the same edge where the request is captured.
// Assumes: take is high for one edge per access; CW >= WSW+1, LCW and 4.
module csbus_req_capture
    import csbus_pkg::*;
#(
    parameter int AW  = 16,
    parameter int WSW = 4,
    parameter int LCW = 3,
    parameter int CW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic           cfg_ext_term,
    input  logic           cfg_relax,
    input  logic           cfg_hold_ext,
    input  logic           cfg_latch_delay,
    input  logic [LCW-1:0] cfg_latch_cycles,
    input  logic [1:0]     cfg_cs_delay,
    input  logic [WSW-1:0] cfg_wait,
    output logic [CW-1:0]  lat_m1_now,
    output logic           acc_write,
    output logic [AW-1:0]  acc_addr,
    output logic           acc_ext_term,
    output logic           acc_relax,
    output logic           acc_cs_late,
    output logic [CW-1:0]  setup_len,
    output logic [CW-1:0]  wait_len,
    output logic [CW-1:0]  gap_len
);

    localparam int WLW = WSW + 1;

    logic [CW-1:0]  setup_d;
    logic [WLW-1:0] wait_d;
    logic [3:0]     gap_d;

    // Latch-enable length minus one; a programmed zero behaves as one cycle.
    always_comb begin
        if (cfg_latch_delay && (cfg_latch_cycles != '0))
            lat_m1_now = CW'(cfg_latch_cycles - 1'b1);
        else
            lat_m1_now = '0;
    end

    // Setup, wait and gap lengths derived from the raw options.
    always_comb begin
        if (cfg_cs_delay == 2'b00)
            setup_d = '0;
        else if (cfg_relax)
            setup_d = CW'(2);
        else
            setup_d = CW'(1);
        wait_d = cfg_relax ? {cfg_wait, 1'b0} : {1'b0, cfg_wait};
        gap_d  = req_write ? 4'd0 : read_gap_cycles(cfg_relax, cfg_hold_ext);
    end

    // Hold the access parameters stable for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_write    <= 1'b0;
            acc_addr     <= '0;
            acc_ext_term <= 1'b0;
            acc_relax    <= 1'b0;
            acc_cs_late  <= 1'b0;
            setup_len    <= '0;
            wait_len     <= '0;
            gap_len      <= '0;
        end else if (take) begin
            acc_write    <= req_write;
            acc_addr     <= req_addr;
            acc_ext_term <= cfg_ext_term;
            acc_relax    <= cfg_relax;
            acc_cs_late  <= (cfg_cs_delay != 2'b00);
            setup_len    <= setup_d;
            wait_len     <= CW'(wait_d);
            gap_len      <= CW'(gap_d);
        end
    end

endmodule

// File: rtl/csbus_phase_seq.sv
// Module: csbus_phase_seq
// Walks one access through latch, setup, active, end and gap phases with a
// single shared down-counter. The active phase ends on the acknowledge, or
// in internal mode also when the counter reaches zero.
// Assumes: the length inputs are stable from the cycle after take onward.
module csbus_phase_seq
    import csbus_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [CW-1:0] lat_m1_now,
    input  logic [CW-1:0] setup_len,
    input  logic [CW-1:0] wait_len,
    input  logic [CW-1:0] gap_len,
    input  logic          ext_term,
    input  logic          ext_ack,
    output logic          take,
    output phase_t        phase
);

    phase_t        phase_d;
    logic [CW-1:0] cnt, cnt_d;
    logic          cnt_zero;
    logic          term;

    assign cnt_zero = (cnt == '0);
    assign take     = (phase == PH_IDLE) && req_valid;
    // End of the active window: acknowledge always, counter only in internal mode.
    assign term     = ext_ack || (!ext_term && cnt_zero);

    // Next phase and counter value.
    always_comb begin
        phase_d = phase;
        cnt_d   = cnt;
        unique case (phase)
            PH_IDLE: begin
                if (take) begin
                    phase_d = PH_LATCH;
                    cnt_d   = lat_m1_now;
                end
            end
            PH_LATCH: begin
                if (!cnt_zero) begin
                    cnt_d = cnt - 1'b1;
                end else if (setup_len != '0) begin
                    phase_d = PH_SETUP;
                    cnt_d   = setup_len - 1'b1;
                end else begin
                    phase_d = PH_ACTIVE;
                    cnt_d   = wait_len;
                end
            end
            PH_SETUP: begin
                if (!cnt_zero) begin
                    cnt_d = cnt - 1'b1;
                end else begin
                    phase_d = PH_ACTIVE;
                    cnt_d   = wait_len;
                end
            end
            PH_ACTIVE: begin
                if (term)
                    phase_d = PH_END;
                else if (!cnt_zero)
                    cnt_d = cnt - 1'b1;
            end
            PH_END: begin
                if (gap_len != '0) begin
                    phase_d = PH_GAP;
                    cnt_d   = gap_len - 1'b1;
                end else begin
                    phase_d = PH_IDLE;
                end
            end
            PH_GAP: begin
                if (!cnt_zero)
                    cnt_d = cnt - 1'b1;
                else
                    phase_d = PH_IDLE;
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_d;
            cnt   <= cnt_d;
        end
    end

endmodule

// File: rtl/csbus_strobe_gen.sv
// Module: csbus_strobe_gen
// Decodes the bus strobes from the registered phase and captured options.
// Every output depends only on registers, so no input reaches the pins
// combinationally.
// Assumes: phase and the acc_* inputs come straight from registers.
module csbus_strobe_gen
    import csbus_pkg::*;
#(
    parameter int AW = 16
) (
    input  phase_t        phase,
    input  logic          acc_write,
    input  logic          acc_relax,
    input  logic          acc_cs_late,
    input  logic [AW-1:0] acc_addr,
    output logic          req_ready,
    output logic [AW-1:0] bus_addr,
    output logic          bus_ale,
    output logic          bus_cs,
    output logic          bus_we,
    output logic          bus_oe,
    output logic          acc_done
);

    logic in_act, in_end, on_bus, early_we, early_cs;

    assign in_act   = (phase == PH_ACTIVE);
    assign in_end   = (phase == PH_END);
    assign on_bus   = (phase == PH_LATCH) || (phase == PH_SETUP) || in_act || in_end;
    // Relaxed writes drop the write strobe, and a delayed select, in the closing cycle.
    assign early_we = acc_write && acc_relax;
    assign early_cs = early_we && acc_cs_late;

    // Strobe decode per phase.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        bus_addr  = on_bus ? acc_addr : '0;
        bus_ale   = (phase == PH_LATCH);
        bus_cs    = in_act || (in_end && !early_cs);
        bus_we    = acc_write && (in_act || (in_end && !early_we));
        bus_oe    = !acc_write && (in_act || in_end);
        acc_done  = in_end;
    end

endmodule

// File: rtl/csbus_timer.sv
// Module: csbus_timer (top)
// Per-access strobe timing controller for one chip-select bank of an
// asynchronous external bus. Request capture, phase sequencing and strobe
// decode are separate submodules.
// Assumes: options are valid with req_valid; ext_ack is synchronous to clk.
module csbus_timer
    import csbus_pkg::*;
#(
    parameter int AW  = 16,
    parameter int WSW = 4,
    parameter int LCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic           cfg_ext_term,
    input  logic           cfg_relax,
    input  logic           cfg_hold_ext,
    input  logic           cfg_latch_delay,
    input  logic [LCW-1:0] cfg_latch_cycles,
    input  logic [1:0]     cfg_cs_delay,
    input  logic [WSW-1:0] cfg_wait,
    input  logic           ext_ack,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_ale,
    output logic           bus_cs,
    output logic           bus_we,
    output logic           bus_oe,
    output logic           acc_done
);

    // The counter covers doubled waits, latch lengths and the 8-cycle gap.
    localparam int CW = max_w(max_w(WSW + 1, LCW), 4);

    logic          take;
    phase_t        phase;
    logic [CW-1:0] lat_m1_now, setup_len, wait_len, gap_len;
    logic          acc_write, acc_ext_term, acc_relax, acc_cs_late;
    logic [AW-1:0] acc_addr;

    csbus_req_capture #(.AW(AW), .WSW(WSW), .LCW(LCW), .CW(CW)) i_capture (
        .clk              (clk),
        .rst_n            (rst_n),
        .take             (take),
        .req_write        (req_write),
        .req_addr         (req_addr),
        .cfg_ext_term     (cfg_ext_term),
        .cfg_relax        (cfg_relax),
        .cfg_hold_ext     (cfg_hold_ext),
        .cfg_latch_delay  (cfg_latch_delay),
        .cfg_latch_cycles (cfg_latch_cycles),
        .cfg_cs_delay     (cfg_cs_delay),
        .cfg_wait         (cfg_wait),
        .lat_m1_now       (lat_m1_now),
        .acc_write        (acc_write),
        .acc_addr         (acc_addr),
        .acc_ext_term     (acc_ext_term),
        .acc_relax        (acc_relax),
        .acc_cs_late      (acc_cs_late),
        .setup_len        (setup_len),
        .wait_len         (wait_len),
        .gap_len          (gap_len)
    );

    csbus_phase_seq #(.CW(CW)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .lat_m1_now (lat_m1_now),
        .setup_len  (setup_len),
        .wait_len   (wait_len),
        .gap_len    (gap_len),
        .ext_term   (acc_ext_term),
        .ext_ack    (ext_ack),
        .take       (take),
        .phase      (phase)
    );

    csbus_strobe_gen #(.AW(AW)) i_strobe (
        .phase       (phase),
        .acc_write   (acc_write),
        .acc_relax   (acc_relax),
        .acc_cs_late (acc_cs_late),
        .acc_addr    (acc_addr),
        .req_ready   (req_ready),
        .bus_addr    (bus_addr),
        .bus_ale     (bus_ale),
        .bus_cs      (bus_cs),
        .bus_we      (bus_we),
        .bus_oe      (bus_oe),
        .acc_done    (acc_done)
    );

endmodule

// File: rtl/csbus_timer_chk.sv
// Module: csbus_timer_chk
// Port-level protocol checks for csbus_timer, attached with bind below.
// Assumes: the top-level strobes are active high.
module csbus_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic bus_ale,
    input logic bus_cs,
    input logic bus_we,
    input logic bus_oe,
    input logic acc_done
);

    // A taken request starts the latch phase on the next cycle.
    p_accept_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_ale);

    // The sequencer is never ready while any strobe or done is active.
    p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale || bus_cs || bus_we || bus_oe || acc_done) |-> !req_ready);

    // The latch phase carries no select or direction strobe.
    p_latch_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> !(bus_cs || bus_we || bus_oe));

    // The two direction strobes never overlap.
    p_dir_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_oe));

    // Done lasts a single cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    // Done follows a cycle with chip select active.
    p_done_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> $past(bus_cs));

endmodule

bind csbus_timer csbus_timer_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_ale   (bus_ale),
    .bus_cs    (bus_cs),
    .bus_we    (bus_we),
    .bus_oe    (bus_oe),
    .acc_done  (acc_done)
);

// File: tb/test_csbus_timer.sv
// Bench: sweeps direction, relax, hold, setup, latch options, wait counts,
// termination mode and acknowledge placement, and predicts every cycle.
module test_csbus_timer;

    localparam int  AW       = 16;
    localparam int  WSW      = 4;
    localparam int  LCW      = 3;
    localparam time CLK_PER  = 10ns;
    localparam int  WD_LIMIT = 190000;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           req_valid;
    logic           req_ready;
    logic           req_write;
    logic [AW-1:0]  req_addr;
    logic           cfg_ext_term, cfg_relax, cfg_hold_ext, cfg_latch_delay;
    logic [LCW-1:0] cfg_latch_cycles;
    logic [1:0]     cfg_cs_delay;
    logic [WSW-1:0] cfg_wait;
    logic           ext_ack;
    logic [AW-1:0]  bus_addr;
    logic           bus_ale, bus_cs, bus_we, bus_oe, acc_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PER / 2) clk = ~clk;

    csbus_timer #(.AW(AW), .WSW(WSW), .LCW(LCW)) i_csbus_timer (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_ready        (req_ready),
        .req_write        (req_write),
        .req_addr         (req_addr),
        .cfg_ext_term     (cfg_ext_term),
        .cfg_relax        (cfg_relax),
        .cfg_hold_ext     (cfg_hold_ext),
        .cfg_latch_delay  (cfg_latch_delay),
        .cfg_latch_cycles (cfg_latch_cycles),
        .cfg_cs_delay     (cfg_cs_delay),
        .cfg_wait         (cfg_wait),
        .ext_ack          (ext_ack),
        .bus_addr         (bus_addr),
        .bus_ale          (bus_ale),
        .bus_cs           (bus_cs),
        .bus_we           (bus_we),
        .bus_oe           (bus_oe),
        .acc_done         (acc_done)
    );

    task automatic check(input string tag, input int k, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, k, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // One access: drive the request, then predict and compare every cycle.
    task automatic run_access(input bit w, input bit rx, input bit hx, input int acs,
                              input bit ead, input int lc, input int wt, input bit ex,
                              input int ap, input logic [AW-1:0] addr);
        int L, S, W, A, G, T, act0;
        bit early, sel_early, in_l, in_s, in_a, in_e, in_g;
        L  = (ead && lc != 0) ? lc : 1;
        S  = (acs == 0) ? 0 : (rx ? 2 : 1);
        W  = rx ? 2 * wt : wt;
        early = !ex && ap >= 0 && ap < W;
        A  = ex ? ap + 1 : (early ? ap + 1 : W + 1);
        G  = w ? 0 : (rx ? (hx ? 8 : 4) : (hx ? 1 : 0));
        act0 = L + S + 1;
        T  = L + S + A + 1;
        sel_early = w && rx && acs != 0;
        check("R1 ready before request", 0, req_ready, 1);
        req_valid        = 1'b1;
        req_write        = w;
        req_addr         = addr;
        cfg_ext_term     = ex;
        cfg_relax        = rx;
        cfg_hold_ext     = hx;
        cfg_latch_delay  = ead;
        cfg_latch_cycles = LCW'(lc);
        cfg_cs_delay     = 2'(acs);
        cfg_wait         = WSW'(wt);
        ext_ack          = 1'b0;
        for (int k = 1; k <= T + G; k++) begin
            @(negedge clk);
            in_l = (k <= L);
            in_s = (k > L) && (k <= L + S);
            in_a = (k >= act0) && (k < T);
            in_e = (k == T);
            in_g = (k > T);
            check(in_g ? "R10 busy in gap" : "R1 busy", k, req_ready, 0);
            check("R2 ale", k, bus_ale, in_l);
            check("R2 addr", k, bus_addr, (in_l || in_s || in_a || in_e) ? addr : '0);
            check(in_e ? "R8 cs end" : "R3 cs", k, bus_cs, in_a || (in_e && !sel_early));
            check(in_e ? "R8 we end" : "R9 we", k, bus_we, w && (in_a || (in_e && !rx)));
            check("R9 oe", k, bus_oe, !w && (in_a || in_e));
            check(ex ? "R6 done" : (early ? "R5 done" : (ap == W ? "R5 coincident done" : "R4 done")),
                  k, acc_done, in_e);
            // R11: stray acknowledges in the first latch cycle and the done cycle.
            ext_ack = (k == 1) || (k == T) || (ap >= 0 && k == act0 + ap);
        end
        @(negedge clk);
        ext_ack = 1'b0;
        check("R11 idle after stray ack", T + G + 1, {bus_ale, bus_cs, bus_we, bus_oe, acc_done}, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", WD_LIMIT, WD_LIMIT);
        summary();
        $finish;
    end

    // Stimulus: reset checks, then the configuration sweep.
    initial begin
        int n;
        int waits[3] = '{0, 2, 15};
        int acss[3]  = '{0, 1, 3};
        int lcs[2]   = '{0, 3};
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        cfg_ext_term = 1'b0; cfg_relax = 1'b0; cfg_hold_ext = 1'b0; cfg_latch_delay = 1'b0;
        cfg_latch_cycles = '0; cfg_cs_delay = '0; cfg_wait = '0; ext_ack = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        check("R1 reset ready", 0, req_ready, 1);
        check("R2 reset ale/addr", 0, {bus_ale, bus_addr}, 0);
        check("R9 reset strobes", 0, {bus_cs, bus_we, bus_oe, acc_done}, 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        n = 0;
        for (int w = 0; w < 2; w++)
        for (int rx = 0; rx < 2; rx++)
        for (int hx = 0; hx < 2; hx++)
        for (int ai = 0; ai < 3; ai++)
        for (int ead = 0; ead < 2; ead++)
        for (int li = 0; li < 2; li++)
        for (int wi = 0; wi < 3; wi++)
        for (int ex = 0; ex < 2; ex++)
        for (int pi = 0; pi < 3; pi++) begin
            int W, ap;
            W = rx ? 2 * waits[wi] : waits[wi];
            if (ex) ap = (pi == 0) ? 0 : ((pi == 1) ? W : W + 3);
            else    ap = (pi == 0) ? -1 : ((pi == 1) ? W : ((W > 0) ? 0 : -1));
            n++;
            run_access(w[0], rx[0], hx[0], acss[ai], ead[0], lcs[li], waits[wi], ex[0], ap,
                       AW'(16'hA000 ^ (n * 16'h0137)));
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 ready after sweep", 0, req_ready, 1);
        summary();
        $finish;
    end

endmodule